// File: doc/BRIEF.md
# DMA Request Edge-Capture Latch

This block sits in front of one channel of a DMA controller and decides when that channel has work pending. It watches an external request pin and, when a chosen edge appears, it sets a pending-request flag. The flag stays set until software clears it or the transfer engine starts the operand transfer that serves it. A second mode hands the flag wholly to software: writing 1 raises it and writing 0 drops it, while the pin is ignored.

A small register port holds a control word and the flag. The control word carries a 6-bit source selector, a 2-bit edge selector and two enables. A source value of zero means software triggering. The pending request is passed to the transfer engine only when both enables are set. In hardware-source mode a software write of 1 to the flag is not allowed. The block drops such a write and pulses an error output.

Bring-up order: program the source and edge selectors, clear the flag, then set both enables.

Top module: `dma_req_latch`

## Requirements
- R1: After reset the flag, the control word, `req_pending` and `prot_err` are all 0, and every register address reads 0.
- R2: With source select 0 (software mode), writing 1 to status bit 0 sets the flag and writing 0 clears it. Edges on `dreq_in` never set the flag in this mode.
- R3: With a non-zero source and edge code 00 (rising), a rise of `dreq_in` sets the flag. The flag becomes visible two clock edges after `dreq_in` is first sampled high.
- R4: Edge code 01 (falling) sets the flag on a fall of `dreq_in`, with the same latency as R3.
- R5: Edge code 10 (both) sets the flag on either a rise or a fall of `dreq_in`.
- R6: Once set, the flag holds whatever `dreq_in` does, until a clear condition occurs.
- R7: A software write of 0 to status bit 0 clears the flag in hardware-source mode.
- R8: A one-cycle `xfer_start` strobe clears the flag at that clock edge.
- R9: In hardware-source mode, a write of 1 to status bit 0 leaves the flag unchanged. It also drives `prot_err` high for exactly the following cycle.
- R10: The control word is at address 0, with source in bits 5:0, edge code in bits 9:8, transfer-start enable in bit 16 and channel enable in bit 17. The flag is status bit 0 at address 1. All other bits, and all other addresses, read 0.
- R11: `req_pending` equals the flag ANDed with both enable bits.
- R12: If a flag set and a clear (an `xfer_start` strobe or a write of 0) fall in the same cycle, the set wins and the flag is 1 afterwards.
- R13: Edge code 11 is reserved and never sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq_in | input | 1 | External request pin, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from `reg_addr` |
| xfer_start | input | 1 | Operand-transfer start strobe from the transfer engine |
| req_pending | output | 1 | Gated pending request to the transfer engine |
| prot_err | output | 1 | One-cycle pulse for a forbidden write of 1 in hardware mode |

## Verification
Register writes and `xfer_start` act on the flag at the clock edge that samples them. `prot_err` is high during the cycle that follows that edge. A pin change counts two edges from the first edge that samples it: one for the synchronizer, one for the flag register. The vector table encodes this by expecting a flag only two rows after the row in which the pin first changes. Every row is checked half a period after its clock edge, with the address parked on the status register.

// File: rtl/dreq_pkg.sv
`timescale 1ns/1ps
package dreq_pkg;

  localparam int SRC_W          = 6;
  localparam int SENSE_W        = 2;
  localparam int CTRL_SRC_LSB   = 0;
  localparam int CTRL_SENSE_LSB = 8;
  localparam int CTRL_START_BIT = 16;
  localparam int CTRL_CHAN_BIT  = 17;
  localparam int STAT_FLAG_BIT  = 0;
  localparam int ADDR_CTRL      = 0;
  localparam int ADDR_STAT      = 1;

  typedef enum logic [SENSE_W-1:0] {
    SENSE_RISE = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_BOTH = 2'b10,
    SENSE_NONE = 2'b11
  } sense_e;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    sense_e           sense;
    logic             start_en;
    logic             chan_en;
  } cfg_t;

  // edge qualification for a given sense code
  function automatic logic edge_hit(sense_e s, logic cur, logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (s)
      SENSE_RISE: edge_hit = rise;
      SENSE_FALL: edge_hit = fall;
      SENSE_BOTH: edge_hit = rise | fall;
      default:    edge_hit = 1'b0;
    endcase
  endfunction

  // sticky flag update, set has priority
  function automatic logic next_flag(logic cur, logic set, logic clr);
    next_flag = set | (cur & ~clr);
  endfunction

  function automatic logic is_sw_mode(logic [SRC_W-1:0] src);
    is_sw_mode = (src == '0);
  endfunction

endpackage

// File: rtl/dreq_sync.sv
`timescale 1ns/1ps
module dreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic cur,
  output logic prev
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];
  end

  assign cur = chain[STAGES-1];
endmodule

// File: rtl/dreq_edge.sv
`timescale 1ns/1ps
module dreq_edge
  import dreq_pkg::*;
(
  input  sense_e sense,
  input  logic   sw_mode,
  input  logic   cur,
  input  logic   prev,
  output logic   edge_evt
);
  always_comb begin
    edge_evt = 1'b0;
    if (!sw_mode) edge_evt = edge_hit(sense, cur, prev);
  end
endmodule

// File: rtl/dreq_cfg_regs.sv
`timescale 1ns/1ps
module dreq_cfg_regs
  import dreq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              flag_q,
  output logic [DATA_W-1:0] reg_rdata,
  output cfg_t              cfg,
  output logic              wr_flag,
  output logic              wr_val
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);

  logic wr_ctrl;
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_flag = reg_wr && (reg_addr == A_STAT);
  assign wr_val  = reg_wdata[STAT_FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_ctrl) begin
      cfg.src      <= reg_wdata[CTRL_SRC_LSB +: SRC_W];
      cfg.sense    <= sense_e'(reg_wdata[CTRL_SENSE_LSB +: SENSE_W]);
      cfg.start_en <= reg_wdata[CTRL_START_BIT];
      cfg.chan_en  <= reg_wdata[CTRL_CHAN_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTRL) begin
      reg_rdata[CTRL_SRC_LSB +: SRC_W]     = cfg.src;
      reg_rdata[CTRL_SENSE_LSB +: SENSE_W] = cfg.sense;
      reg_rdata[CTRL_START_BIT]            = cfg.start_en;
      reg_rdata[CTRL_CHAN_BIT]             = cfg.chan_en;
    end else if (reg_addr == A_STAT) begin
      reg_rdata[STAT_FLAG_BIT] = flag_q;
    end
  end

  // reserved write bits carry no meaning
  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[DATA_W-1:CTRL_CHAN_BIT+1],
                          reg_wdata[CTRL_START_BIT-1:CTRL_SENSE_LSB+SENSE_W],
                          reg_wdata[CTRL_SENSE_LSB-1:SRC_W]};
endmodule

// File: rtl/dreq_flag.sv
`timescale 1ns/1ps
module dreq_flag
  import dreq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sw_mode,
  input  logic edge_evt,
  input  logic wr_flag,
  input  logic wr_val,
  input  logic xfer_start,
  output logic flag_q,
  output logic set_evt,
  output logic clr_evt,
  output logic hw_wr1,
  output logic sw_wr1,
  output logic prot_err
);
  assign sw_wr1  = sw_mode & wr_flag & wr_val;
  assign hw_wr1  = ~sw_mode & wr_flag & wr_val;
  assign set_evt = sw_wr1 | edge_evt;
  assign clr_evt = xfer_start | (wr_flag & ~wr_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      prot_err <= 1'b0;
    end else begin
      flag_q   <= next_flag(flag_q, set_evt, clr_evt);
      prot_err <= hw_wr1;
    end
  end
endmodule

// File: rtl/dma_req_latch.sv
`timescale 1ns/1ps
module dma_req_latch
  import dreq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dreq_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              xfer_start,
  output logic              req_pending,
  output logic              prot_err
);
  cfg_t cfg;
  logic sw_mode, cur, prev, edge_evt;
  logic wr_flag, wr_val;
  logic flag_q, set_evt, clr_evt, hw_wr1, sw_wr1;

  assign sw_mode = is_sw_mode(cfg.src);

  dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(dreq_in), .cur(cur), .prev(prev)
  );

  dreq_edge u_edge (
    .sense(cfg.sense), .sw_mode(sw_mode), .cur(cur), .prev(prev),
    .edge_evt(edge_evt)
  );

  dreq_cfg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .flag_q(flag_q), .reg_rdata(reg_rdata),
    .cfg(cfg), .wr_flag(wr_flag), .wr_val(wr_val)
  );

  dreq_flag u_flag (
    .clk(clk), .rst_n(rst_n), .sw_mode(sw_mode), .edge_evt(edge_evt),
    .wr_flag(wr_flag), .wr_val(wr_val), .xfer_start(xfer_start),
    .flag_q(flag_q), .set_evt(set_evt), .clr_evt(clr_evt),
    .hw_wr1(hw_wr1), .sw_wr1(sw_wr1), .prot_err(prot_err)
  );

  assign req_pending = flag_q & cfg.start_en & cfg.chan_en;
endmodule

// File: rtl/dreq_chk.sv
`timescale 1ns/1ps
module dreq_chk
  import dreq_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   flag_q,
  input logic   set_evt,
  input logic   clr_evt,
  input logic   hw_wr1,
  input logic   sw_wr1,
  input logic   sw_mode,
  input logic   edge_evt,
  input sense_e sense,
  input logic   start_en,
  input logic   chan_en,
  input logic   req_pending,
  input logic   prot_err
);
  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_evt) |=> flag_q);
  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);
  // R8
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !flag_q);
  // R9
  hw_wr1_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_wr1 |=> prot_err);
  // R9
  hw_wr1_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_wr1 && !flag_q && !edge_evt) |=> !flag_q);
  // R2
  sw_pin_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_mode && !sw_wr1 && !flag_q) |=> !flag_q);
  // R13
  none_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == SENSE_NONE) |-> !edge_evt);
  // R11
  pending_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_pending |-> (flag_q && start_en && chan_en));
endmodule

bind dma_req_latch dreq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .set_evt(set_evt),
  .clr_evt(clr_evt), .hw_wr1(hw_wr1), .sw_wr1(sw_wr1), .sw_mode(sw_mode),
  .edge_evt(edge_evt), .sense(cfg.sense), .start_en(cfg.start_en),
  .chan_en(cfg.chan_en), .req_pending(req_pending), .prot_err(prot_err)
);

// File: tb/dma_req_latch_tb_top.sv
`timescale 1ns/1ps
module dma_req_latch_tb_top;
  localparam int DW = 32;
  localparam int AW = 2;
  localparam logic [1:0] AC = 2'd0;
  localparam logic [1:0] AS = 2'd1;

  typedef struct packed {
    logic          wr;
    logic [1:0]    addr;
    logic [31:0]   data;
    logic          req;
    logic          xs;
    logic          ef;
    logic          ep;
    logic          ee;
    logic [3:0]    rq;
  } vec_t;

  // Expected values follow the two-edge pin latency: a pin value first
  // sampled in row i shows in the flag at row i+2.
  localparam int NV = 44;
  localparam vec_t VEC [NV] = '{
    '{1'b1, AC, 32'h0003_0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // hw, rising
    '{1'b1, AS, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},
    '{1'b0, AS, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
    '{1'b0, AS, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
    '{1'b0, AS, 32'h0,         1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd3},  // R3 set
    '{1'b0, AS, 32'h0,         1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 sticky
    '{1'b0, AS, 32'h0,         1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd6},
    '{1'b0, AS, 32'h0,         1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 clear
    '{1'b1, AS, 32'h1,         1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 illegal
    '{1'b0, AS, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},
    '{1'b1, AC, 32'h0003_0101, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // falling
    '{1'b0, AS, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},
    '{1'b0, AS, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},
    '{1'b0, AS, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},
    '{1'b0, AS, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},
    '{1'b0, AS, 32'h0,         1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 set
    '{1'b1, AS, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 clear
    '{1'b1, AC, 32'h0000_0200, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // sw mode
    '{1'b0, AS, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
    '{1'b0, AS, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 pin ignored
    '{1'b1, AS, 32'h1,         1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 sw set
    '{1'b1, AC, 32'h0002_0000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd11},
    '{1'b1, AC, 32'h0003_0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd11}, // R11
    '{1'b1, AS, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 sw clear
    '{1'b1, AC, 32'h0003_0201, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // both edges
    '{1'b0, AS, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},
    '{1'b0, AS, 32'h0,         1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5},  // R5 fall
    '{1'b0, AS, 32'h0,         1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8},
    '{1'b0, AS, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},
    '{1'b0, AS, 32'h0,         1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd12}, // R12 vs xfer
    '{1'b0, AS, 32'h0,         1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd6},
    '{1'b1, AS, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},
    '{1'b1, AC, 32'h0003_0301, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd13}, // reserved code
    '{1'b0, AS, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd13},
    '{1'b0, AS, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd13},
    '{1'b0, AS, 32'h0,         1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd13},
    '{1'b0, AS, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd13},
    '{1'b0, AS, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd13},
    '{1'b0, AS, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd13}, // R13
    '{1'b1, AC, 32'h0003_0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
    '{1'b0, AS, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
    '{1'b0, AS, 32'h0,         1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
    '{1'b1, AS, 32'h0,         1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd12}, // R12 vs write 0
    '{1'b0, AS, 32'h0,         1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd6}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dreq_in = 1'b0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = AS;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          xfer_start = 1'b0;
  logic          req_pending;
  logic          prot_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dma_req_latch #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dreq_in(dreq_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer_start(xfer_start), .req_pending(req_pending), .prot_err(prot_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    reg_wr = 1'b0; reg_addr = AS; reg_wdata = '0; xfer_start = 1'b0;
  endtask

  task automatic read_at(input logic [1:0] a, output logic [31:0] v);
    reg_wr = 1'b0; reg_addr = a; #0.5; v = reg_rdata;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at every address
    read_at(AC, v); chk("R1 ctrl", v, 32'h0);
    read_at(AS, v); chk("R1 status", v, 32'h0);
    read_at(2'd2, v); chk("R1 unused addr", v, 32'h0);
    chk("R1 pending", {31'b0, req_pending}, 32'h0);
    chk("R1 prot_err", {31'b0, prot_err}, 32'h0);

    // vector table: each row applied before one edge, checked after it
    for (int i = 0; i < NV; i++) begin
      reg_wr = VEC[i].wr; reg_addr = VEC[i].addr; reg_wdata = VEC[i].data;
      dreq_in = VEC[i].req; xfer_start = VEC[i].xs;
      @(negedge clk);
      idle_inputs();
      #0.5;
      chk($sformatf("R%0d row %0d flag", VEC[i].rq, i), {31'b0, reg_rdata[0]}, {31'b0, VEC[i].ef});
      chk($sformatf("R%0d row %0d pending", VEC[i].rq, i), {31'b0, req_pending}, {31'b0, VEC[i].ep});
      chk($sformatf("R%0d row %0d prot_err", VEC[i].rq, i), {31'b0, prot_err}, {31'b0, VEC[i].ee});
    end

    // R10 register layout and reserved bits
    read_at(AC, v); chk("R10 ctrl readback", v, 32'h0003_0001);
    read_at(AS, v); chk("R10 status only bit0", v, 32'h1);
    reg_wr = 1'b1; reg_addr = AC; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk); idle_inputs();
    read_at(AC, v); chk("R10 ctrl reserved zero", v, 32'h0003_033F);
    read_at(2'd3, v); chk("R10 unused addr", v, 32'h0);

    // R9 prot_err lasts a single cycle
    reg_wr = 1'b1; reg_addr = AS; reg_wdata = 32'h1;
    @(negedge clk); idle_inputs();
    chk("R9 err pulse", {31'b0, prot_err}, 32'h1);
    @(negedge clk);
    chk("R9 err drops", {31'b0, prot_err}, 32'h0);

    // R7 write with reserved bits set and bit0 clear still clears
    reg_wr = 1'b1; reg_addr = AS; reg_wdata = 32'hFFFF_FFFE;
    @(negedge clk); idle_inputs();
    read_at(AS, v); chk("R7 clear via write", v, 32'h0);

    // R1 reset in mid-run with flag set in software mode
    reg_wr = 1'b1; reg_addr = AC; reg_wdata = 32'h0003_0000;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AS; reg_wdata = 32'h1;
    @(negedge clk); idle_inputs();
    chk("R2 sw set before reset", {31'b0, req_pending}, 32'h1);
    rst_n = 1'b0;
    #0.5;
    read_at(AS, v); chk("R1 flag after reset", v, 32'h0);
    read_at(AC, v); chk("R1 ctrl after reset", v, 32'h0);
    chk("R1 pending after reset", {31'b0, req_pending}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule